// File: doc/BRIEF.md
# Trap Entry and Return Controller

This block serves the execute stage of a processor for two control-transfer operations. For a software trap it turns the base and offset operands into a vector number that always lands in the upper half of an 8-bit vector space. For a return-from-trap it takes the current privilege state and decides four things: the next program counter, whether the status bits are rewritten, and whether an illegal-instruction request or a halt request is raised.

An operation is presented with a one-cycle valid strobe and a kind select. The decision is made combinationally in that cycle and registered. On the next cycle a done pulse appears, together with the result and the request pulses. The write-enable, new-S and new-ET outputs feed the status register, so the status update takes effect one edge after acceptance.

The return checks go in a fixed order. The supervisor bit comes first, then the exception-enable bit, then whether the debug field of the instruction matches the current running mode. Only the first case that matches takes effect.

Top module: `trap_ret_ctl`

## Requirements
- R1: After reset every output is 0.
- R2: A trap operation (op_is_ret=0) gives vec_vld=1 and vec_num = ((trap_base + trap_ofs) mod 128) + 128 in the cycle after op_vld. vec_num is therefore always between 0x80 and 0xFF. pc_vld, psr_wr, illegal_req and halt_req stay 0.
- R3: On a return with psr_s=0, next_pc = cur_pc + 4. halt_req equals the inverse of psr_et. No status write and no illegal request occur.
- R4: On a return with psr_s=1 and psr_et=1, illegal_req=1 and next_pc = cur_pc + 4. No halt and no status write occur. This holds whatever the mode and debug field are.
- R5: On a return with psr_s=1, psr_et=0, dbg_mode=0 and ret_dbg_fld=0, next_pc = save_pc, psr_wr=1, new_et=1 and new_s = psr_ps.
- R6: On a return with psr_s=1, psr_et=0, dbg_mode=1 and ret_dbg_fld=1, next_pc = save_dbg_pc, psr_wr=1, new_et = save_dbg_et, new_s = save_dbg_s and dbg_clr=1.
- R7: On a return with psr_s=1, psr_et=0 and a debug field that does not match dbg_mode, next_pc = cur_pc + 4. psr_wr, dbg_clr and both requests are 0, and new_s and new_et equal psr_s and psr_et.
- R8: done is high for exactly the one cycle after each cycle with op_vld=1. In a cycle after op_vld=0, done, vec_vld, pc_vld, psr_wr, dbg_clr, illegal_req and halt_req are all 0.
- R9: At most one of halt_req, illegal_req and psr_wr is high in any cycle. dbg_clr is high only together with psr_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_vld | input | 1 | Operation strobe, one cycle |
| op_is_ret | input | 1 | 1 = return-from-trap, 0 = software trap |
| trap_base | input | ARG_W | Trap base operand |
| trap_ofs | input | ARG_W | Trap offset operand |
| cur_pc | input | PC_W | PC of the current instruction |
| psr_s | input | 1 | Supervisor bit |
| psr_ps | input | 1 | Previous-supervisor bit |
| psr_et | input | 1 | Exception-enable bit |
| dbg_mode | input | 1 | Processor is in debug running mode |
| ret_dbg_fld | input | 1 | Debug field of the return instruction |
| save_pc | input | PC_W | Saved PC for a normal return |
| save_dbg_pc | input | PC_W | Saved PC for a debug return |
| save_dbg_s | input | 1 | Saved supervisor bit for a debug return |
| save_dbg_et | input | 1 | Saved enable bit for a debug return |
| done | output | 1 | Operation completed, one-cycle pulse |
| vec_vld | output | 1 | vec_num carries a trap vector |
| vec_num | output | 8 | Trap vector number |
| pc_vld | output | 1 | next_pc carries a return target |
| next_pc | output | PC_W | Next program counter |
| psr_wr | output | 1 | Write new_s and new_et to the status register |
| new_s | output | 1 | Updated supervisor bit |
| new_et | output | 1 | Updated exception-enable bit |
| dbg_clr | output | 1 | Leave debug running mode |
| illegal_req | output | 1 | Illegal-instruction request |
| halt_req | output | 1 | Halt request |

## Verification
A wrong priority between the S, ET and mode-match checks would show in the first cycle after a single return strobe. The port would give the wrong target PC or a status write where none is due, or a halt or illegal request would be swapped for another. The bench therefore sweeps every combination of the five control bits and both saved debug bits. A vector adder that drops or keeps the wrong carry would show up in vec_num straight away, so the bench sweeps the base over a full byte against offsets that wrap and that are negative. Done and the request pulses that stick or repeat are visible on the cycle after each strobe.

// File: rtl/trap_ret_ctl.sv
module trap_ret_ctl #(
  parameter int PC_W  = 32,
  parameter int ARG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_vld,
  input  logic             op_is_ret,
  input  logic [ARG_W-1:0] trap_base,
  input  logic [ARG_W-1:0] trap_ofs,
  input  logic [PC_W-1:0]  cur_pc,
  input  logic             psr_s,
  input  logic             psr_ps,
  input  logic             psr_et,
  input  logic             dbg_mode,
  input  logic             ret_dbg_fld,
  input  logic [PC_W-1:0]  save_pc,
  input  logic [PC_W-1:0]  save_dbg_pc,
  input  logic             save_dbg_s,
  input  logic             save_dbg_et,
  output logic             done,
  output logic             vec_vld,
  output logic [7:0]       vec_num,
  output logic             pc_vld,
  output logic [PC_W-1:0]  next_pc,
  output logic             psr_wr,
  output logic             new_s,
  output logic             new_et,
  output logic             dbg_clr,
  output logic             illegal_req,
  output logic             halt_req
);

  localparam int VEC_LO = 7;

  logic [ARG_W-1:0] sum;
  logic [7:0]       vec_d;
  logic             unused_sum_hi;

  assign sum           = trap_base + trap_ofs;
  assign vec_d         = 8'h80 + {1'b0, sum[VEC_LO-1:0]};
  assign unused_sum_hi = ^sum[ARG_W-1:VEC_LO];

  logic [PC_W-1:0] pc_step;
  logic [PC_W-1:0] d_pc;
  logic            d_halt, d_ill, d_wr, d_s, d_et, d_clr;

  assign pc_step = cur_pc + PC_W'(4);

  always_comb begin
    d_pc   = pc_step;
    d_halt = 1'b0;
    d_ill  = 1'b0;
    d_wr   = 1'b0;
    d_s    = psr_s;
    d_et   = psr_et;
    d_clr  = 1'b0;
    if (!psr_s) begin
      d_halt = !psr_et;
    end else if (psr_et) begin
      d_ill = 1'b1;
    end else if (!dbg_mode && !ret_dbg_fld) begin
      d_pc = save_pc;
      d_wr = 1'b1;
      d_et = 1'b1;
      d_s  = psr_ps;
    end else if (dbg_mode && ret_dbg_fld) begin
      d_pc  = save_dbg_pc;
      d_wr  = 1'b1;
      d_et  = save_dbg_et;
      d_s   = save_dbg_s;
      d_clr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done        <= 1'b0;
      vec_vld     <= 1'b0;
      vec_num     <= '0;
      pc_vld      <= 1'b0;
      next_pc     <= '0;
      psr_wr      <= 1'b0;
      new_s       <= 1'b0;
      new_et      <= 1'b0;
      dbg_clr     <= 1'b0;
      illegal_req <= 1'b0;
      halt_req    <= 1'b0;
    end else begin
      done        <= op_vld;
      vec_vld     <= op_vld && !op_is_ret;
      pc_vld      <= op_vld && op_is_ret;
      psr_wr      <= op_vld && op_is_ret && d_wr;
      dbg_clr     <= op_vld && op_is_ret && d_clr;
      illegal_req <= op_vld && op_is_ret && d_ill;
      halt_req    <= op_vld && op_is_ret && d_halt;
      if (op_vld && !op_is_ret) begin
        vec_num <= vec_d;
        new_s   <= psr_s;
        new_et  <= psr_et;
      end
      if (op_vld && op_is_ret) begin
        next_pc <= d_pc;
        new_s   <= d_s;
        new_et  <= d_et;
      end
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld |=> done);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_vld |=> !done && !pc_vld && !vec_vld && !psr_wr && !halt_req && !illegal_req);
  p_vec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld |-> vec_num[7]);
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({halt_req, illegal_req, psr_wr}));
  p_clr_with_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_clr |-> psr_wr);
  p_user_ret_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld && op_is_ret && !psr_s |=> next_pc == $past(cur_pc) + PC_W'(4) && !psr_wr && !illegal_req);
  p_enabled_ret_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld && op_is_ret && psr_s && psr_et |=> illegal_req && !halt_req);
  p_norm_ret_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld && op_is_ret && psr_s && !psr_et && !dbg_mode && !ret_dbg_fld |=> psr_wr && new_et && !dbg_clr);
  p_dbg_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld && op_is_ret && psr_s && !psr_et && dbg_mode && ret_dbg_fld |=> dbg_clr && next_pc == $past(save_dbg_pc));
  p_mismatch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld && op_is_ret && psr_s && !psr_et && (dbg_mode != ret_dbg_fld) |=> !psr_wr && !dbg_clr && !halt_req && !illegal_req);

endmodule

// File: tb/sim_trap_ret_ctl.sv
`timescale 1ns/1ps
module sim_trap_ret_ctl;
  localparam int PC_W = 32;
  localparam int ARG_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_vld = 1'b0, op_is_ret = 1'b0;
  logic [ARG_W-1:0] trap_base = '0, trap_ofs = '0;
  logic [PC_W-1:0] cur_pc = '0, save_pc = '0, save_dbg_pc = '0;
  logic psr_s = 0, psr_ps = 0, psr_et = 0, dbg_mode = 0, ret_dbg_fld = 0;
  logic save_dbg_s = 0, save_dbg_et = 0;
  logic done, vec_vld, pc_vld, psr_wr, new_s, new_et, dbg_clr, illegal_req, halt_req;
  logic [7:0] vec_num;
  logic [PC_W-1:0] next_pc;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  trap_ret_ctl #(.PC_W(PC_W), .ARG_W(ARG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_is_ret(op_is_ret),
    .trap_base(trap_base), .trap_ofs(trap_ofs), .cur_pc(cur_pc),
    .psr_s(psr_s), .psr_ps(psr_ps), .psr_et(psr_et), .dbg_mode(dbg_mode),
    .ret_dbg_fld(ret_dbg_fld), .save_pc(save_pc), .save_dbg_pc(save_dbg_pc),
    .save_dbg_s(save_dbg_s), .save_dbg_et(save_dbg_et),
    .done(done), .vec_vld(vec_vld), .vec_num(vec_num), .pc_vld(pc_vld),
    .next_pc(next_pc), .psr_wr(psr_wr), .new_s(new_s), .new_et(new_et),
    .dbg_clr(dbg_clr), .illegal_req(illegal_req), .halt_req(halt_req));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op();
    @(negedge clk) op_vld = 1'b1;
    @(negedge clk) op_vld = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [ARG_W-1:0] ofs_set [7];
    logic [PC_W-1:0] exp_pc;
    logic exp_wr, exp_clr, exp_ill, exp_halt, exp_s, exp_et;
    logic [7:0] exp_vec;
    ofs_set[0] = 0; ofs_set[1] = 1; ofs_set[2] = 32'h7F; ofs_set[3] = 32'h80;
    ofs_set[4] = 32'hFFFF_FFFF; ofs_set[5] = 32'hFFFF_FF7F; ofs_set[6] = 32'h1234_5678;

    repeat (3) @(negedge clk);
    check("R1 done", done, 0);
    check("R1 reqs", {vec_vld, pc_vld, psr_wr, dbg_clr, illegal_req, halt_req, new_s, new_et}, 0);
    check("R1 next_pc", next_pc, 0);
    check("R1 vec_num", vec_num, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle done", done, 0);

    op_is_ret = 1'b0;
    for (int b = 0; b < 256; b++) begin
      for (int k = 0; k < 7; k++) begin
        trap_base = 32'(b) * 32'h0101_0101;
        trap_ofs = ofs_set[k];
        exp_vec = 8'((((trap_base + trap_ofs) % 128) + 128));
        run_op();
        check("R2 vec_num", vec_num, exp_vec);
        check("R2 vec_vld", {vec_vld, done}, 2'b11);
        check("R2 no ret outs", {pc_vld, psr_wr, illegal_req, halt_req}, 0);
      end
    end

    op_is_ret = 1'b1;
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 128; c++) begin
        {psr_s, psr_ps, psr_et, dbg_mode, ret_dbg_fld, save_dbg_s, save_dbg_et} = 7'(c);
        cur_pc = p ? 32'hFFFF_FFFC : 32'(c) * 32'h0001_0010;
        save_pc = 32'hA000_0000 + 32'(c);
        save_dbg_pc = 32'hB000_0000 + 32'(c);
        exp_pc = cur_pc + 4; exp_wr = 0; exp_clr = 0; exp_ill = 0; exp_halt = 0;
        exp_s = psr_s; exp_et = psr_et;
        if (!psr_s) exp_halt = !psr_et;
        else if (psr_et) exp_ill = 1;
        else if (!dbg_mode && !ret_dbg_fld) begin
          exp_pc = save_pc; exp_wr = 1; exp_et = 1; exp_s = psr_ps;
        end else if (dbg_mode && ret_dbg_fld) begin
          exp_pc = save_dbg_pc; exp_wr = 1; exp_et = save_dbg_et; exp_s = save_dbg_s; exp_clr = 1;
        end
        run_op();
        if (!psr_s) begin
          check("R3 next_pc", next_pc, exp_pc);
          check("R3 halt/ill/wr", {halt_req, illegal_req, psr_wr}, {exp_halt, 2'b00});
        end else if (psr_et) begin
          check("R4 next_pc", next_pc, exp_pc);
          check("R4 halt/ill/wr", {halt_req, illegal_req, psr_wr}, 3'b010);
        end else if (dbg_mode == ret_dbg_fld && !dbg_mode) begin
          check("R5 next_pc", next_pc, exp_pc);
          check("R5 wr/s/et/clr", {psr_wr, new_s, new_et, dbg_clr}, {1'b1, exp_s, 1'b1, 1'b0});
        end else if (dbg_mode == ret_dbg_fld) begin
          check("R6 next_pc", next_pc, exp_pc);
          check("R6 wr/s/et/clr", {psr_wr, new_s, new_et, dbg_clr}, {1'b1, exp_s, exp_et, 1'b1});
        end else begin
          check("R7 next_pc", next_pc, exp_pc);
          check("R7 outs", {psr_wr, dbg_clr, illegal_req, halt_req, new_s, new_et}, {4'b0, exp_s, exp_et});
        end
        check("R9 flags", {halt_req, illegal_req, psr_wr, dbg_clr}, {exp_halt, exp_ill, exp_wr, exp_clr});
        check("R8 done/pc_vld", {done, pc_vld, vec_vld}, 3'b110);
      end
    end

    @(negedge clk);
    check("R8 done falls", {done, pc_vld, psr_wr, dbg_clr, illegal_req, halt_req}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule